// File: doc/BRIEF.md
# Expansion Card Address Decoder with Enable Bit

This block sits on the host side of a single peripheral card attached to an 8-bit expansion bus with a 16-bit address. It watches the address and control lines and produces the strobes the card needs. A ROM select covers the 2 KiB window at 0xD800..0xDFFF, and the same strobe is driven out as a disable for the host's built-in floating-point ROM so the two never drive the data bus together. A register enable covers the 256-byte page at 0xD100..0xD1FF and is split into even and odd register strobes by address bit 0. An external select, which switches off host RAM, is raised for that page only when the host also signals an external access.

Every strobe is gated by a one-bit card-enable register. Software sets or clears it by writing data bit 0 to address 0xD1FF. While the bit is clear the card is invisible: all strobes stay low. The bit is cleared at once when the host reset input goes low. The reset is released through a two-stage synchronizer, so the bit cannot load until the third rising clock edge after release. All strobes are combinational functions of the current address, the host external-enable input and the card-enable bit.

Top module: `xbc_card_decode`

## Requirements
- R1: `rom_sel` is 1 exactly when `card_en` is 1 and `bus_addr` lies in 0xD800..0xDFFF inclusive; otherwise it is 0.
- R2: `math_dis` equals `rom_sel` for every address and enable state, so the host math ROM is disabled whenever the card ROM is selected.
- R3: `reg_en` is 1 exactly when `card_en` is 1 and `bus_addr` lies in 0xD100..0xD1FF inclusive.
- R4: `ext_sel` is 1 exactly when `reg_en` is 1 and `host_ext_en` is 1.
- R5: While `reg_en` is 1, `reg_even` is 1 when `bus_addr[0]` is 0 and `reg_odd` is 1 when `bus_addr[0]` is 1. Both are 0 while `reg_en` is 0.
- R6: At a rising `clk` edge with `bus_wr_stb` = 1, `bus_rnw` = 0 (0 means write) and `bus_addr` = 0xD1FF, `card_en` takes the value of `bus_d0` after that edge. A 1 enables the card and a 0 disables it.
- R7: `card_en` keeps its value at any edge where `bus_wr_stb` is 0, `bus_rnw` is 1, or `bus_addr` differs from 0xD1FF.
- R8: `rst_n` = 0 clears `card_en` immediately without a clock edge. After `rst_n` returns to 1, enable writes at the first two rising edges are ignored and a write at the third edge is taken.
- R9: While `card_en` is 0, all of `rom_sel`, `math_dis`, `reg_en`, `reg_even`, `reg_odd` and `ext_sel` are 0 for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the enable bit loads on its rising edge |
| rst_n | input | 1 | Host reset, active low, asynchronous assert |
| bus_addr | input | 16 | CPU address bus |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_wr_stb | input | 1 | Write strobe, qualifies the enable-bit load at a clock edge |
| bus_d0 | input | 1 | Data bus bit 0 |
| host_ext_en | input | 1 | Host external-access enable |
| card_en | output | 1 | Card-enable bit (1 = card selected) |
| rom_sel | output | 1 | Card ROM select, active high |
| math_dis | output | 1 | Host math-ROM disable, active high |
| reg_en | output | 1 | Card register-page enable, active high |
| reg_even | output | 1 | Even register strobe, active high |
| reg_odd | output | 1 | Odd register strobe, active high |
| ext_sel | output | 1 | Host RAM turn-off select, active high |

## Verification
The six strobes are due within the same cycle as the address that causes them, so the bench changes the address with the write strobe held low and compares 1 ns later. It does this for all 65536 addresses, once with the enable bit clear and once with it set, and compares against window limits computed arithmetically. An enable write is applied at a falling edge and captured at the next rising edge, so `card_en` is checked at the falling edge that follows. The reset clear is checked 1 ns after `rst_n` falls. After release, the bench counts rising edges to show that the third edge is the first to load.

// File: rtl/xbc_pkg.sv
`timescale 1ns/1ps
package xbc_pkg;
  // Active-high strobe bundle produced by the decoder.
  typedef struct packed {
    logic rom;
    logic regs;
    logic even;
    logic odd;
    logic ext;
  } xbc_sel_t;
endpackage

// File: rtl/xbc_rst_sync.sv
`timescale 1ns/1ps
module xbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d[0] = 1'b1;
  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    assign sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/xbc_window.sv
`timescale 1ns/1ps
module xbc_window #(
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BASE      = '0,
  parameter int             SPAN_LOG2 = 0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] LOW_BITS = AW'((32'd1 << SPAN_LOG2) - 32'd1);
  localparam logic [AW-1:0] TAG_MASK = ~LOW_BITS;

  assign hit = ((addr ^ BASE) & TAG_MASK) == '0;
endmodule

// File: rtl/xbc_en_latch.sv
`timescale 1ns/1ps
module xbc_en_latch #(
  parameter int            AW         = 16,
  parameter logic [AW-1:0] LATCH_ADDR = 16'hD1FF
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic [AW-1:0] addr,
  input  logic          rnw,
  input  logic          wr_stb,
  input  logic          d0,
  output logic          en_q
);
  logic addr_hit;
  logic load_en;
  logic en_d;

  xbc_window #(.AW(AW), .BASE(LATCH_ADDR), .SPAN_LOG2(0)) u_hit (
    .addr (addr),
    .hit  (addr_hit)
  );

  assign load_en = wr_stb & ~rnw & addr_hit;

  always_comb begin
    en_d = en_q;
    if (load_en) en_d = d0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) en_q <= 1'b0;
    else          en_q <= en_d;
  end
endmodule

// File: rtl/xbc_card_decode.sv
`timescale 1ns/1ps
module xbc_card_decode #(
  parameter int            AW            = 16,
  parameter logic [AW-1:0] ROM_BASE      = 16'hD800,
  parameter int            ROM_SPAN_LOG2 = 11,
  parameter logic [AW-1:0] REG_BASE      = 16'hD100,
  parameter int            REG_SPAN_LOG2 = 8,
  parameter logic [AW-1:0] LATCH_ADDR    = 16'hD1FF,
  parameter int            SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rnw,
  input  logic          bus_wr_stb,
  input  logic          bus_d0,
  input  logic          host_ext_en,
  output logic          card_en,
  output logic          rom_sel,
  output logic          math_dis,
  output logic          reg_en,
  output logic          reg_even,
  output logic          reg_odd,
  output logic          ext_sel
);
  import xbc_pkg::*;

  logic     rst_q_n;
  logic     rom_hit;
  logic     reg_hit;
  xbc_sel_t sel;

  xbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  xbc_en_latch #(.AW(AW), .LATCH_ADDR(LATCH_ADDR)) u_latch (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .addr    (bus_addr),
    .rnw     (bus_rnw),
    .wr_stb  (bus_wr_stb),
    .d0      (bus_d0),
    .en_q    (card_en)
  );

  xbc_window #(.AW(AW), .BASE(ROM_BASE), .SPAN_LOG2(ROM_SPAN_LOG2)) u_rom_win (
    .addr (bus_addr),
    .hit  (rom_hit)
  );

  xbc_window #(.AW(AW), .BASE(REG_BASE), .SPAN_LOG2(REG_SPAN_LOG2)) u_reg_win (
    .addr (bus_addr),
    .hit  (reg_hit)
  );

  always_comb begin
    sel      = '0;
    sel.rom  = card_en & rom_hit;
    sel.regs = card_en & reg_hit;
    sel.even = sel.regs & ~bus_addr[0];
    sel.odd  = sel.regs &  bus_addr[0];
    sel.ext  = sel.regs & host_ext_en;
  end

  assign rom_sel  = sel.rom;
  assign math_dis = sel.rom;
  assign reg_en   = sel.regs;
  assign reg_even = sel.even;
  assign reg_odd  = sel.odd;
  assign ext_sel  = sel.ext;
endmodule

// File: rtl/xbc_card_decode_chk.sv
`timescale 1ns/1ps
module xbc_card_decode_chk #(
  parameter int            AW            = 16,
  parameter logic [AW-1:0] ROM_BASE      = 16'hD800,
  parameter int            ROM_SPAN_LOG2 = 11,
  parameter logic [AW-1:0] REG_BASE      = 16'hD100,
  parameter int            REG_SPAN_LOG2 = 8,
  parameter logic [AW-1:0] LATCH_ADDR    = 16'hD1FF
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rnw,
  input logic          bus_wr_stb,
  input logic          bus_d0,
  input logic          host_ext_en,
  input logic          card_en,
  input logic          rom_sel,
  input logic          math_dis,
  input logic          reg_en,
  input logic          reg_even,
  input logic          reg_odd,
  input logic          ext_sel
);
  localparam logic [AW-1:0] ROM_LAST = ROM_BASE + AW'((32'd1 << ROM_SPAN_LOG2) - 32'd1);
  localparam logic [AW-1:0] REG_LAST = REG_BASE + AW'((32'd1 << REG_SPAN_LOG2) - 32'd1);

  logic wr_hit;
  logic in_rom;
  logic in_reg;
  assign wr_hit = bus_wr_stb && !bus_rnw && (bus_addr == LATCH_ADDR);
  assign in_rom = (bus_addr >= ROM_BASE) && (bus_addr <= ROM_LAST);
  assign in_reg = (bus_addr >= REG_BASE) && (bus_addr <= REG_LAST);

  AST_ROM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    rom_sel |-> (card_en && in_rom)); // R1
  AST_ROM_WHEN_HIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (card_en && in_rom) |-> (rom_sel && math_dis)); // R2
  AST_REG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_en |-> (card_en && in_reg)); // R3
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    ext_sel |-> (reg_en && host_ext_en)); // R4
  AST_PAIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_en |-> ($countones({reg_even, reg_odd}) == 1 && reg_odd == bus_addr[0])); // R5
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_hit |=> (card_en == $past(bus_d0))); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_hit |=> $stable(card_en)); // R7
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    !card_en |-> !(rom_sel || math_dis || reg_en || reg_even || reg_odd || ext_sel)); // R9

  always @(posedge clk) begin
    if (!rst_q_n) begin
      AST_RST_CLEAR: assert (!card_en); // R8
    end
  end
endmodule

bind xbc_card_decode xbc_card_decode_chk #(
  .AW(AW), .ROM_BASE(ROM_BASE), .ROM_SPAN_LOG2(ROM_SPAN_LOG2),
  .REG_BASE(REG_BASE), .REG_SPAN_LOG2(REG_SPAN_LOG2), .LATCH_ADDR(LATCH_ADDR)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
  .bus_wr_stb(bus_wr_stb), .bus_d0(bus_d0), .host_ext_en(host_ext_en),
  .card_en(card_en), .rom_sel(rom_sel), .math_dis(math_dis), .reg_en(reg_en),
  .reg_even(reg_even), .reg_odd(reg_odd), .ext_sel(ext_sel)
);

// File: tb/sim_xbc_card_decode.sv
`timescale 1ns/1ps
module sim_xbc_card_decode;
  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rnw;
  logic        bus_wr_stb;
  logic        bus_d0;
  logic        host_ext_en;
  logic        card_en, rom_sel, math_dis, reg_en, reg_even, reg_odd, ext_sel;

  int n_chk = 0;
  int n_err = 0;

  xbc_card_decode u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_wr_stb(bus_wr_stb), .bus_d0(bus_d0), .host_ext_en(host_ext_en),
    .card_en(card_en), .rom_sel(rom_sel), .math_dis(math_dis), .reg_en(reg_en),
    .reg_even(reg_even), .reg_odd(reg_odd), .ext_sel(ext_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b (addr %h ext %b en %b)",
               tag, act, exp, bus_addr, host_ext_en, card_en);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic d, input logic rnw, input logic stb);
    @(negedge clk);
    bus_addr   = a;
    bus_d0     = d;
    bus_rnw    = rnw;
    bus_wr_stb = stb;
    @(negedge clk);
    bus_wr_stb = 1'b0;
    bus_rnw    = 1'b1;
  endtask

  task automatic sweep(input logic en);
    for (int a = 0; a < 65536; a++) begin
      logic exp_rom, exp_reg, exp_ext;
      bus_addr    = 16'(a);
      host_ext_en = 1'(((a >> 1) ^ (a >> 9)) & 1);
      exp_rom = en && (a >= 55296) && (a <= 57343);
      exp_reg = en && (a >= 53504) && (a <= 53759);
      exp_ext = exp_reg && host_ext_en;
      #1;
      chk("R1 rom_sel", rom_sel, exp_rom);
      chk("R2 math_dis", math_dis, exp_rom);
      chk("R3 reg_en", reg_en, exp_reg);
      chk("R4 ext_sel", ext_sel, exp_ext);
      chk("R5 reg_even", reg_even, exp_reg && (a % 2 == 0));
      chk("R5 reg_odd", reg_odd, exp_reg && (a % 2 == 1));
      if (!en) chk("R9 quiet", rom_sel | reg_en | ext_sel | reg_even | reg_odd | math_dis, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b1; bus_addr = 16'h0000; bus_rnw = 1'b1; bus_wr_stb = 1'b0;
    bus_d0 = 1'b0; host_ext_en = 1'b0;
    #2 rst_n = 1'b0;
    #1 chk("R8 reset clears", card_en, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle after reset", card_en, 1'b0);

    sweep(1'b0);

    bus_cycle(16'hD1FF, 1'b1, 1'b1, 1'b1);
    chk("R7 read ignored", card_en, 1'b0);
    bus_cycle(16'hD1FE, 1'b1, 1'b0, 1'b1);
    chk("R7 other addr ignored", card_en, 1'b0);
    bus_cycle(16'hD1FF, 1'b1, 1'b0, 1'b0);
    chk("R7 no strobe ignored", card_en, 1'b0);
    bus_cycle(16'hD1FF, 1'b1, 1'b0, 1'b1);
    chk("R6 write 1 enables", card_en, 1'b1);

    sweep(1'b1);

    bus_cycle(16'hD1FF, 1'b0, 1'b1, 1'b1);
    chk("R7 read keeps 1", card_en, 1'b1);
    bus_cycle(16'h01FF, 1'b0, 1'b0, 1'b1);
    chk("R7 alias addr keeps 1", card_en, 1'b1);
    bus_cycle(16'hD1FF, 1'b0, 1'b0, 1'b1);
    chk("R6 write 0 disables", card_en, 1'b0);
    bus_addr = 16'hD100; #1;
    chk("R9 off reg page", reg_en, 1'b0);
    bus_cycle(16'hD1FF, 1'b1, 1'b0, 1'b1);
    chk("R6 re-enable", card_en, 1'b1);

    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R8 async clear", card_en, 1'b0);
    @(negedge clk);
    bus_addr = 16'hD1FF; bus_d0 = 1'b1; bus_rnw = 1'b0; bus_wr_stb = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 edge 1 ignored", card_en, 1'b0);
    @(negedge clk);
    chk("R8 edge 2 ignored", card_en, 1'b0);
    @(negedge clk);
    chk("R8 edge 3 taken", card_en, 1'b1);
    bus_wr_stb = 1'b0; bus_rnw = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule